// File: doc/BRIEF.md
# Push-Button Power-State Sequencer

This block steers a power-characterisation load from four active-low push buttons. One button clears the whole demo, one steps a 2-bit rate setting, one steps a resource level, and one flips an output-enable flag. Each button is synchronised, debounced with a counter filter, and turned into a single-cycle step pulse, so one press moves one step however long it is held and however it bounces.

The resource level turns on a thermometer of enables for replicated load slices, one slice per level. The same level picks how many 8-pin output groups toggle. The rate setting becomes a clock enable taken from a fixed 100 MHz reference, fired every cycle, two cycles in three, one in three, or never. While the flag is set, every active output group inverts on each cycle the enable fires. The two settings and the flag are shown directly on LEDs.

Top module: `pwr_step_ctrl`

## Requirements
- R1: While `btn_reset_n` is low, and after it is released, the demo starts with rate code 00, resource code 0, the output flag clear and all output pins 0.
- R2: Each press of `btn_freq_n` adds one to the 2-bit rate code on `led_freq`, and code 11 wraps to 00.
- R3: Each press of `btn_res_n` adds one to the 5-bit binary resource code on `led_res`, counting 0 to 18, and code 18 wraps to 0.
- R4: `slice_en` bit i is 1 exactly when i is not greater than the resource code, so codes 0 to 18 light 1 to 19 slices.
- R5: Each press of `btn_oe_n` inverts the output flag, and `led_oe` shows the flag.
- R6: With the flag clear, all `out_pins` are 0. With the flag set and resource code n, pin groups 0 to n (group g is bits 8g+7 down to 8g) invert together on every cycle in which `tick_en` is 1, and groups above n stay 0.
- R7: `tick_en` is 1 on every cycle for rate code 11, on two cycles in every three for code 10, on one cycle in three for code 01, and never for code 00.
- R8: A button held low for fewer cycles than the debounce length changes no state. A press held far longer than that length steps its setting exactly once, and releasing the button steps nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz reference clock |
| btn_reset_n | input | 1 | Active-low demo reset button |
| btn_freq_n | input | 1 | Active-low rate step button |
| btn_res_n | input | 1 | Active-low resource step button |
| btn_oe_n | input | 1 | Active-low output flag button |
| led_freq | output | 2 | Current rate code |
| led_res | output | 5 | Current resource code |
| led_oe | output | 1 | Output flag |
| slice_en | output | 19 | Thermometer enables for the load slices |
| tick_en | output | 1 | Clock enable at the selected rate |
| out_pins | output | 152 | Toggling output pins, 19 groups of 8 |

## Verification
The hardest state to reach is the resource wrap from 18 back to 0. It needs nineteen full debounced press-and-release cycles on one button. The stimulus walks every code on the way and checks the full 19-slice thermometer just before the wrap. Toggling pins are checked by sampling two consecutive cycles at the full rate with the flag set, because groups can differ in phase after the level changes. Glitch rejection is checked with a low pulse shorter than the filter length, and a very long hold must still give only one step.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    localparam int unsigned FREQ_W = 2;

    typedef enum logic [FREQ_W-1:0] {
        RATE_STOP = 2'b00,
        RATE_LOW  = 2'b01,
        RATE_MID  = 2'b10,
        RATE_FULL = 2'b11
    } rate_e;

    localparam logic [1:0] PHASE_LAST = 2'd2;
endpackage

// File: rtl/pwr_btn_filter.sv
module pwr_btn_filter #(
    parameter int unsigned DEB_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic press
);
    localparam int unsigned CW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          stable;
        logic [CW-1:0] cnt;
        logic          press;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d       = flt_q;
        flt_d.sync  = {flt_q.sync[0], btn_n};
        flt_d.press = 1'b0;
        if (flt_q.sync[1] == flt_q.stable) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(DEB_CYCLES - 1)) begin
            flt_d.cnt    = '0;
            flt_d.stable = flt_q.sync[1];
            flt_d.press  = flt_q.stable & ~flt_q.sync[1];
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '{sync: 2'b11, stable: 1'b1, cnt: '0, press: 1'b0};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign press = flt_q.press;
endmodule

// File: rtl/pwr_rate_gen.sv
module pwr_rate_gen
    import pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] code,
    output logic              tick
);
    logic [1:0] phase_d, phase_q;

    always_comb begin
        phase_d = (phase_q == PHASE_LAST) ? 2'd0 : phase_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 2'd0;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        unique case (rate_e'(code))
            RATE_FULL: tick = 1'b1;
            RATE_MID:  tick = (phase_q != PHASE_LAST);
            RATE_LOW:  tick = (phase_q == 2'd0);
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwr_step_ctrl.sv
module pwr_step_ctrl
    import pwr_pkg::*;
#(
    parameter int unsigned DEB_CYCLES     = 1000000,
    parameter int unsigned N_SLICES       = 19,
    parameter int unsigned PINS_PER_SLICE = 8,
    localparam int unsigned RES_W = $clog2(N_SLICES),
    localparam int unsigned OUT_W = N_SLICES * PINS_PER_SLICE
) (
    input  logic              clk,
    input  logic              btn_reset_n,
    input  logic              btn_freq_n,
    input  logic              btn_res_n,
    input  logic              btn_oe_n,
    output logic [FREQ_W-1:0] led_freq,
    output logic [RES_W-1:0]  led_res,
    output logic              led_oe,
    output logic [N_SLICES-1:0] slice_en,
    output logic              tick_en,
    output logic [OUT_W-1:0]  out_pins
);
    localparam logic [RES_W-1:0] RES_MAX = RES_W'(N_SLICES - 1);

    // reset: asserted at once, released through two flops
    logic [1:0] rst_pipe_q;
    logic       rst_n_q;

    always_ff @(posedge clk or negedge btn_reset_n) begin
        if (!btn_reset_n) begin
            rst_pipe_q <= 2'b00;
        end else begin
            rst_pipe_q <= {rst_pipe_q[0], 1'b1};
        end
    end
    assign rst_n_q = rst_pipe_q[1];

    // button step pulses
    logic [2:0] btn_raw_n;
    logic [2:0] btn_step;
    logic       freq_adv, res_adv, oe_adv;

    assign btn_raw_n = {btn_oe_n, btn_res_n, btn_freq_n};

    for (genvar b = 0; b < 3; b++) begin : g_btn
        pwr_btn_filter #(.DEB_CYCLES(DEB_CYCLES)) u_flt (
            .clk   (clk),
            .rst_n (rst_n_q),
            .btn_n (btn_raw_n[b]),
            .press (btn_step[b])
        );
    end
    assign freq_adv = btn_step[0];
    assign res_adv  = btn_step[1];
    assign oe_adv   = btn_step[2];

    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic [RES_W-1:0]  res;
        logic              oe;
        logic [OUT_W-1:0]  pins;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [N_SLICES-1:0] therm;
    logic                tick;

    pwr_rate_gen u_rate (
        .clk   (clk),
        .rst_n (rst_n_q),
        .code  (ctl_q.freq),
        .tick  (tick)
    );

    for (genvar s = 0; s < N_SLICES; s++) begin : g_therm
        assign therm[s] = (RES_W'(s) <= ctl_q.res);
    end

    always_comb begin
        ctl_d = ctl_q;
        if (freq_adv) begin
            ctl_d.freq = ctl_q.freq + 1'b1;
        end
        if (res_adv) begin
            ctl_d.res = (ctl_q.res == RES_MAX) ? '0 : ctl_q.res + 1'b1;
        end
        if (oe_adv) begin
            ctl_d.oe = ~ctl_q.oe;
        end
        for (int g = 0; g < N_SLICES; g++) begin
            if (!ctl_q.oe || !therm[g]) begin
                ctl_d.pins[g*PINS_PER_SLICE +: PINS_PER_SLICE] = '0;
            end else if (tick) begin
                ctl_d.pins[g*PINS_PER_SLICE +: PINS_PER_SLICE] =
                    ~ctl_q.pins[g*PINS_PER_SLICE +: PINS_PER_SLICE];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n_q) begin
        if (!rst_n_q) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign led_freq = ctl_q.freq;
    assign led_res  = ctl_q.res;
    assign led_oe   = ctl_q.oe;
    assign slice_en = therm;
    assign tick_en  = tick;
    assign out_pins = ctl_q.pins;
endmodule

// File: rtl/pwr_step_chk.sv
module pwr_step_chk #(
    parameter int unsigned N_SLICES = 19,
    parameter int unsigned RES_W    = 5,
    parameter int unsigned OUT_W    = 152
) (
    input logic                clk,
    input logic                rst_n,
    input logic                freq_adv,
    input logic                res_adv,
    input logic                oe_adv,
    input logic [1:0]          led_freq,
    input logic [RES_W-1:0]    led_res,
    input logic                led_oe,
    input logic [N_SLICES-1:0] slice_en,
    input logic                tick_en,
    input logic [OUT_W-1:0]    out_pins
);
    localparam logic [RES_W-1:0] RES_TOP = RES_W'(N_SLICES - 1);

    AST_FREQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        freq_adv |=> led_freq == 2'($past(led_freq) + 2'd1)); // R2
    AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_adv |=> $stable(led_freq)); // R8
    AST_RES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        res_adv |=> led_res == (($past(led_res) == RES_TOP) ? '0 : RES_W'($past(led_res) + 1'b1))); // R3
    AST_RES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        led_res <= RES_TOP); // R3
    AST_SLICE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slice_en) == int'(led_res) + 1); // R4
    AST_OE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        oe_adv |=> led_oe != $past(led_oe)); // R5
    AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !led_oe |=> out_pins == '0); // R6
    AST_RATE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        led_freq == 2'b00 |-> !tick_en); // R7
    AST_RATE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        led_freq == 2'b11 |-> tick_en); // R7
endmodule

bind pwr_step_ctrl pwr_step_chk #(
    .N_SLICES (N_SLICES),
    .RES_W    (RES_W),
    .OUT_W    (OUT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .freq_adv (freq_adv),
    .res_adv  (res_adv),
    .oe_adv   (oe_adv),
    .led_freq (led_freq),
    .led_res  (led_res),
    .led_oe   (led_oe),
    .slice_en (slice_en),
    .tick_en  (tick_en),
    .out_pins (out_pins)
);

// File: tb/tb_pwr_step_ctrl.sv
module tb_pwr_step_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 8;
    localparam int NS         = 19;
    localparam int OW         = NS * 8;
    localparam int HOLD       = DEB + 6;

    logic          clk = 1'b0;
    logic          btn_reset_n = 1'b0;
    logic          btn_freq_n = 1'b1;
    logic          btn_res_n = 1'b1;
    logic          btn_oe_n = 1'b1;
    logic [1:0]    led_freq;
    logic [4:0]    led_res;
    logic          led_oe;
    logic [NS-1:0] slice_en;
    logic          tick_en;
    logic [OW-1:0] out_pins;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_step_ctrl #(.DEB_CYCLES(DEB)) dut (
        .clk         (clk),
        .btn_reset_n (btn_reset_n),
        .btn_freq_n  (btn_freq_n),
        .btn_res_n   (btn_res_n),
        .btn_oe_n    (btn_oe_n),
        .led_freq    (led_freq),
        .led_res     (led_res),
        .led_oe      (led_oe),
        .slice_en    (slice_en),
        .tick_en     (tick_en),
        .out_pins    (out_pins)
    );

    // vector: {button 0=rate 1=resource 2=flag, exp rate, exp resource, exp flag}
    localparam int NV = 10;
    localparam logic [9:0] VEC [NV] = '{
        {2'd0, 2'd1, 5'd0, 1'b0},
        {2'd0, 2'd2, 5'd0, 1'b0},
        {2'd1, 2'd2, 5'd1, 1'b0},
        {2'd2, 2'd2, 5'd1, 1'b1},
        {2'd0, 2'd3, 5'd1, 1'b1},
        {2'd1, 2'd3, 5'd2, 1'b1},
        {2'd0, 2'd0, 5'd2, 1'b1},
        {2'd2, 2'd0, 5'd2, 1'b0},
        {2'd1, 2'd0, 5'd3, 1'b0},
        {2'd0, 2'd1, 5'd3, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic press(input int which, input int hold);
        @(negedge clk);
        case (which)
            0: btn_freq_n = 1'b0;
            1: btn_res_n  = 1'b0;
            default: btn_oe_n = 1'b0;
        endcase
        cycles(hold);
        btn_freq_n = 1'b1;
        btn_res_n  = 1'b1;
        btn_oe_n   = 1'b1;
        cycles(HOLD);
    endtask

    task automatic do_reset();
        @(negedge clk);
        btn_reset_n = 1'b0;
        cycles(3);
        btn_reset_n = 1'b1;
        cycles(4);
    endtask

    task automatic count_ticks(input int exp, input string req);
        int cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tick_en) cnt++;
        end
        check(cnt == exp, req, cnt, exp);
    endtask

    // flag set, rate 11: active groups invert each cycle, others stay 0
    task automatic check_pins(input int n);
        logic [OW-1:0] p1, p2;
        bit ok = 1'b1;
        @(negedge clk); p1 = out_pins;
        @(negedge clk); p2 = out_pins;
        for (int g = 0; g < NS; g++) begin
            if (g <= n) begin
                if (!(p1[g*8 +: 8] == 8'h00 || p1[g*8 +: 8] == 8'hff)) ok = 1'b0;
                if (p2[g*8 +: 8] != ~p1[g*8 +: 8]) ok = 1'b0;
            end else if (p1[g*8 +: 8] != 8'h00 || p2[g*8 +: 8] != 8'h00) begin
                ok = 1'b0;
            end
        end
        check(ok, "R6 active groups toggle", p2[31:0], ~p1[31:0]);
    endtask

    initial begin
        cycles(3);
        // R1 during reset
        check(led_freq == 2'd0 && led_res == 5'd0 && !led_oe && out_pins == '0,
              "R1 held reset", {led_freq, led_res, led_oe}, 0);
        btn_reset_n = 1'b1;
        cycles(4);
        check(led_freq == 2'd0 && led_res == 5'd0 && !led_oe && slice_en == 19'd1,
              "R1 after release", {slice_en, led_freq, led_res, led_oe}, 32'h1 << 8);

        // vector walk: R2 R3 R5
        for (int v = 0; v < NV; v++) begin
            press(int'(VEC[v][9:8]), HOLD);
            check(led_freq == VEC[v][7:6], "R2 rate code", led_freq, VEC[v][7:6]);
            check(led_res == VEC[v][5:1], "R3 resource code", led_res, VEC[v][5:1]);
            check(led_oe == VEC[v][0], "R5 flag", led_oe, VEC[v][0]);
        end

        // R7 rate patterns (state now rate 01)
        count_ticks(10, "R7 code 01");
        press(0, HOLD);
        count_ticks(20, "R7 code 10");
        press(0, HOLD);
        count_ticks(30, "R7 code 11");
        press(0, HOLD);
        count_ticks(0, "R7 code 00");

        // R6 flag clear -> pins quiet even at full rate
        press(0, HOLD); press(0, HOLD); press(0, HOLD);
        cycles(5);
        check(out_pins == '0, "R6 flag clear pins zero", out_pins[31:0], 0);
        press(2, HOLD);
        check_pins(3);
        press(1, HOLD);
        check_pins(4);
        press(2, HOLD);
        cycles(2);
        check(out_pins == '0, "R6 flag cleared again", out_pins[31:0], 0);

        // R8 short glitch, long hold
        @(negedge clk); btn_freq_n = 1'b0;
        cycles(DEB - 3);
        btn_freq_n = 1'b1;
        cycles(HOLD);
        check(led_freq == 2'd3, "R8 glitch ignored", led_freq, 3);
        press(1, 200);
        check(led_res == 5'd5, "R8 long hold one step", led_res, 5);

        // R1 reset from busy state
        press(2, HOLD);
        do_reset();
        check(led_freq == 2'd0 && led_res == 5'd0 && !led_oe && out_pins == '0,
              "R1 reset mid run", {led_freq, led_res, led_oe}, 0);

        // R3 R4 walk to top and wrap
        for (int k = 1; k <= 18; k++) begin
            press(1, HOLD);
            check(slice_en == NS'((1 << (k + 1)) - 1), "R4 thermometer", slice_en, (1 << (k + 1)) - 1);
        end
        check(led_res == 5'd18, "R3 top code", led_res, 18);
        check(slice_en == '1, "R4 all slices", slice_en, 32'h7ffff);
        press(1, HOLD);
        check(led_res == 5'd0, "R3 wrap to 0", led_res, 0);
        check(slice_en == 19'd1, "R4 after wrap", slice_en, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule